// File: doc/BRIEF.md
# Parallel Converter Sequencer

This block runs one parallel analogue-to-digital converter and one parallel digital-to-analogue converter over a single set of address and data pins. Only one of them can own the pins at a time. For a conversion it lowers the converter select, pulses the read/convert line low for a programmed time and then waits for the converter's ready line. After a programmed read delay it captures the data word, releases the select and raises a one-cycle interrupt. For an output write it drives the address and data, then a write strobe of programmed width, with one setup cycle before the strobe and one hold cycle after it.

A small register port sets the sample width (8 or 16 bits), the timing counts, the conversion address and the trigger enables. It also launches output writes and conversions. A conversion can also be started by an on-chip trigger pulse or by a rising edge on an external trigger line, which is synchronised first. If ready never arrives, a timeout ends the conversion and sets a sticky error flag.

Top module: `pconv_top`

## Requirements
- R1: After reset, the select, read/convert and write strobe outputs are high. Data enable, interrupt, address and data outputs are zero. Register 0 reads 0, register 1 reads 0x0010_0001, register 3 reads 1 and register 7 reads 0.
- R2: A conversion accepted at a clock edge drives the select low from that edge. One edge later, read/convert goes low for CONV cycles, where CONV is register 1 bits [7:0] and a value of 0 counts as 1. It then returns high, and the ready input is sampled on each following edge.
- R3: The ready input is first seen high at some edge. After DLY+1 further edges, where DLY is register 1 bits [15:8], the data input is captured. At that same edge the select rises and the interrupt output goes high for exactly one cycle.
- R4: With register 0 bit 0 set, samples and output data are 16 bits wide. With it clear, captured samples keep only data bits [7:0], zero-extended, and output writes drive data bits [15:8] as zero.
- R5: If ready stays low on TMO consecutive sampling edges, where TMO is register 1 bits [31:16] and 0 counts as 1, the conversion ends. The select rises, there is no interrupt, the sample is kept and register 7 bit 0 is set. That bit stays set until a write of 1 to register 7 bit 0. If a set and a clear fall on the same edge, the set wins.
- R6: A conversion starts on a write to register 5, on a high internal trigger input when register 0 bit 2 is set, or on a rising edge of the external trigger when register 0 bit 1 is set. The external input passes two synchroniser flops, so a rise seen at edge E is accepted at edge E+2. A held level starts only one conversion. A disabled source has no effect.
- R7: While a conversion or an output write is in progress, any start request and any output-write launch is ignored.
- R8: A write to register 4 stores an address (bits [7:0]) and data (bits [23:8]). When idle, it drives them with the data enable from the next edge. After one setup cycle the write strobe goes low for DLEN cycles, where DLEN is register 3 bits [7:0] and 0 counts as 1. One hold cycle follows, after which the data enable drops.
- R9: A conversion drives the address from register 2 bits [7:0]. Between operations, the address and data outputs keep their last values.
- R10: Read data is registered one cycle after the read address. The read layout is: 0 holds the enables (bit 0 width, bit 1 external, bit 2 internal); 1 holds the timing fields; 2 holds the address; 3 holds the strobe width; 4 holds the last output word; 5 reads 0; 6 holds the sample; 7 holds error in bit 0 and busy in bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register write address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 3 | Register read address |
| reg_rdata | output | 32 | Registered read data |
| int_trig | input | 1 | On-chip conversion trigger |
| ext_trig | input | 1 | Asynchronous external conversion trigger |
| cnv_rdy | input | 1 | Converter ready, active high |
| bus_din | input | 16 | Data pins, input side |
| bus_addr | output | 8 | Shared address pins |
| bus_dout | output | 16 | Data pins, output side |
| bus_oe | output | 1 | Data pin drive enable |
| cnv_cs_n | output | 1 | Converter select, active low |
| cnv_rc_n | output | 1 | Read/convert, low during convert |
| dac_wr_n | output | 1 | Output write strobe, active low |
| irq | output | 1 | One-cycle conversion-complete pulse |

## Verification
The bench targets zero timing counts. A design that used a zero count literally would hold read/convert or the strobe low forever, or time out at once. It also targets a timeout of one cycle against a ready line that arrives one cycle late, where an off-by-one in the timeout compare either captures stale data or aborts a good conversion. Starts and output writes issued during a busy conversion would show up as a second select fall or a stray strobe. A long-held external trigger would show up as repeated conversions if edge detection were missing. In 8-bit mode, upper-byte leakage would appear in the captured sample or on the output data.

// File: rtl/pconv_pkg.sv
package pconv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_A_SETUP,
    ST_A_CONV,
    ST_A_WAIT,
    ST_A_HOLD,
    ST_D_SETUP,
    ST_D_STRB,
    ST_D_HOLD
  } seq_st_t;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_ATIM = 3'd1;
  localparam logic [2:0] RA_AADR = 3'd2;
  localparam logic [2:0] RA_DTIM = 3'd3;
  localparam logic [2:0] RA_DWR  = 3'd4;
  localparam logic [2:0] RA_GO   = 3'd5;
  localparam logic [2:0] RA_SMPL = 3'd6;
  localparam logic [2:0] RA_STAT = 3'd7;
endpackage

// File: rtl/pconv_trig.sv
module pconv_trig #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_trig,
  input  logic int_trig,
  input  logic ext_en,
  input  logic int_en,
  input  logic sw_start,
  output logic conv_req
);
  // chain of SYNC flops plus one history flop for the edge detector
  logic [SYNC:0] sh;
  logic          ext_edge;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SYNC-1:0], ext_trig};
  end

  assign ext_edge = sh[SYNC-1] & ~sh[SYNC];
  assign conv_req = sw_start | (int_en & int_trig) | (ext_en & ext_edge);
endmodule

// File: rtl/pconv_regs.sv
module pconv_regs
  import pconv_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int LW = 8,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [2:0]    waddr,
  input  logic [31:0]   wdata,
  input  logic [2:0]    raddr,
  output logic [31:0]   rdata,
  input  logic [DW-1:0] sample,
  input  logic          busy,
  input  logic          tmo_evt,
  output logic          w16,
  output logic          ext_en,
  output logic          int_en,
  output logic [LW-1:0] conv_len,
  output logic [LW-1:0] rd_dly,
  output logic [TW-1:0] tmo_lim,
  output logic [AW-1:0] adc_addr,
  output logic [LW-1:0] dac_len,
  output logic          sw_start,
  output logic          dac_go,
  output logic [AW-1:0] dac_addr_w,
  output logic [DW-1:0] dac_data_w
);
  localparam int DLO = LW;
  localparam int TLO = 2 * LW;
  localparam logic [TW-1:0] TMO_RST = TW'(16);

  logic          err;
  logic [AW-1:0] dac_addr_last;
  logic [DW-1:0] dac_data_last;
  logic [31:0]   rd_mux;

  assign dac_addr_w = wdata[AW-1:0];
  assign dac_data_w = wdata[AW +: DW];
  assign sw_start   = we && (waddr == RA_GO);
  assign dac_go     = we && (waddr == RA_DWR);

  always_ff @(posedge clk) begin
    if (rst) begin
      w16           <= 1'b0;
      ext_en        <= 1'b0;
      int_en        <= 1'b0;
      conv_len      <= LW'(1);
      rd_dly        <= '0;
      tmo_lim       <= TMO_RST;
      adc_addr      <= '0;
      dac_len       <= LW'(1);
      dac_addr_last <= '0;
      dac_data_last <= '0;
    end else if (we) begin
      case (waddr)
        RA_CTRL: begin
          w16    <= wdata[0];
          ext_en <= wdata[1];
          int_en <= wdata[2];
        end
        RA_ATIM: begin
          conv_len <= wdata[LW-1:0];
          rd_dly   <= wdata[DLO +: LW];
          tmo_lim  <= wdata[TLO +: TW];
        end
        RA_AADR: adc_addr <= wdata[AW-1:0];
        RA_DTIM: dac_len  <= wdata[LW-1:0];
        RA_DWR: begin
          dac_addr_last <= dac_addr_w;
          dac_data_last <= dac_data_w;
        end
        default: ;
      endcase
    end
  end

  // sticky timeout flag: a new timeout beats a simultaneous clear
  always_ff @(posedge clk) begin
    if (rst)                                          err <= 1'b0;
    else if (tmo_evt)                                 err <= 1'b1;
    else if (we && (waddr == RA_STAT) && wdata[0])    err <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    case (raddr)
      RA_CTRL: rd_mux[2:0] = {int_en, ext_en, w16};
      RA_ATIM: begin
        rd_mux[LW-1:0]   = conv_len;
        rd_mux[DLO +: LW] = rd_dly;
        rd_mux[TLO +: TW] = tmo_lim;
      end
      RA_AADR: rd_mux[AW-1:0] = adc_addr;
      RA_DTIM: rd_mux[LW-1:0] = dac_len;
      RA_DWR: begin
        rd_mux[AW-1:0]  = dac_addr_last;
        rd_mux[AW +: DW] = dac_data_last;
      end
      RA_SMPL: rd_mux[DW-1:0] = sample;
      RA_STAT: rd_mux[1:0]    = {busy, err};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/pconv_seq.sv
module pconv_seq
  import pconv_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int LW = 8,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          conv_req,
  input  logic          dac_go,
  input  logic [AW-1:0] dac_addr_w,
  input  logic [DW-1:0] dac_data_w,
  input  logic          w16,
  input  logic [LW-1:0] conv_len,
  input  logic [LW-1:0] rd_dly,
  input  logic [TW-1:0] tmo_lim,
  input  logic [AW-1:0] adc_addr,
  input  logic [LW-1:0] dac_len,
  input  logic          rdy,
  input  logic [DW-1:0] din,
  output logic          busy,
  output logic          tmo_evt,
  output logic [DW-1:0] sample,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] dout,
  output logic          oe,
  output logic          cs_n,
  output logic          rc_n,
  output logic          wr_n,
  output logic          irq
);
  localparam int CNTW = (TW > LW) ? TW : LW;
  localparam int HW   = DW / 2;

  seq_st_t         st;
  logic [CNTW-1:0] cnt;
  logic [CNTW-1:0] conv_m1, dac_m1, tmo_m1, dly_x;
  logic [DW-1:0]   din_cut, dac_cut;

  // zero in any length field is treated as one
  always_comb begin
    conv_m1 = (conv_len == '0) ? '0 : CNTW'(conv_len) - CNTW'(1);
    dac_m1  = (dac_len  == '0) ? '0 : CNTW'(dac_len)  - CNTW'(1);
    tmo_m1  = (tmo_lim  == '0) ? '0 : CNTW'(tmo_lim)  - CNTW'(1);
    dly_x   = CNTW'(rd_dly);
    din_cut = w16 ? din : {{(DW-HW){1'b0}}, din[HW-1:0]};
    dac_cut = w16 ? dac_data_w : {{(DW-HW){1'b0}}, dac_data_w[HW-1:0]};
  end

  assign busy    = (st != ST_IDLE);
  assign tmo_evt = (st == ST_A_WAIT) && !rdy && (cnt == tmo_m1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      cs_n   <= 1'b1;
      rc_n   <= 1'b1;
      wr_n   <= 1'b1;
      oe     <= 1'b0;
      addr   <= '0;
      dout   <= '0;
      sample <= '0;
      irq    <= 1'b0;
    end else begin
      irq <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (conv_req) begin
            st   <= ST_A_SETUP;
            cs_n <= 1'b0;
            addr <= adc_addr;
          end else if (dac_go) begin
            st   <= ST_D_SETUP;
            oe   <= 1'b1;
            addr <= dac_addr_w;
            dout <= dac_cut;
          end
        end
        ST_A_SETUP: begin
          st   <= ST_A_CONV;
          rc_n <= 1'b0;
          cnt  <= conv_m1;
        end
        ST_A_CONV: begin
          if (cnt == '0) begin
            st   <= ST_A_WAIT;
            rc_n <= 1'b1;
          end else begin
            cnt <= cnt - CNTW'(1);
          end
        end
        ST_A_WAIT: begin
          if (rdy) begin
            st  <= ST_A_HOLD;
            cnt <= dly_x;
          end else if (cnt == tmo_m1) begin
            st   <= ST_IDLE;
            cs_n <= 1'b1;
          end else begin
            cnt <= cnt + CNTW'(1);
          end
        end
        ST_A_HOLD: begin
          if (cnt == '0) begin
            st     <= ST_IDLE;
            cs_n   <= 1'b1;
            irq    <= 1'b1;
            sample <= din_cut;
          end else begin
            cnt <= cnt - CNTW'(1);
          end
        end
        ST_D_SETUP: begin
          st   <= ST_D_STRB;
          wr_n <= 1'b0;
          cnt  <= dac_m1;
        end
        ST_D_STRB: begin
          if (cnt == '0) begin
            st   <= ST_D_HOLD;
            wr_n <= 1'b1;
          end else begin
            cnt <= cnt - CNTW'(1);
          end
        end
        ST_D_HOLD: begin
          st <= ST_IDLE;
          oe <= 1'b0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pconv_top.sv
module pconv_top #(
  parameter int AW   = 8,
  parameter int DW   = 16,
  parameter int LW   = 8,
  parameter int TW   = 16,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  input  logic [2:0]    reg_raddr,
  output logic [31:0]   reg_rdata,
  input  logic          int_trig,
  input  logic          ext_trig,
  input  logic          cnv_rdy,
  input  logic [DW-1:0] bus_din,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  output logic          cnv_cs_n,
  output logic          cnv_rc_n,
  output logic          dac_wr_n,
  output logic          irq
);
  logic          w16, ext_en, int_en, sw_start, dac_go, conv_req;
  logic          busy, tmo_evt;
  logic [LW-1:0] conv_len, rd_dly, dac_len;
  logic [TW-1:0] tmo_lim;
  logic [AW-1:0] adc_addr, dac_addr_w;
  logic [DW-1:0] dac_data_w, sample;

  pconv_regs #(.AW(AW), .DW(DW), .LW(LW), .TW(TW)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .waddr(reg_addr), .wdata(reg_wdata),
    .raddr(reg_raddr), .rdata(reg_rdata), .sample(sample), .busy(busy),
    .tmo_evt(tmo_evt), .w16(w16), .ext_en(ext_en), .int_en(int_en),
    .conv_len(conv_len), .rd_dly(rd_dly), .tmo_lim(tmo_lim),
    .adc_addr(adc_addr), .dac_len(dac_len), .sw_start(sw_start),
    .dac_go(dac_go), .dac_addr_w(dac_addr_w), .dac_data_w(dac_data_w)
  );

  pconv_trig #(.SYNC(SYNC)) u_trig (
    .clk(clk), .rst(rst), .ext_trig(ext_trig), .int_trig(int_trig),
    .ext_en(ext_en), .int_en(int_en), .sw_start(sw_start), .conv_req(conv_req)
  );

  pconv_seq #(.AW(AW), .DW(DW), .LW(LW), .TW(TW)) u_seq (
    .clk(clk), .rst(rst), .conv_req(conv_req), .dac_go(dac_go),
    .dac_addr_w(dac_addr_w), .dac_data_w(dac_data_w), .w16(w16),
    .conv_len(conv_len), .rd_dly(rd_dly), .tmo_lim(tmo_lim),
    .adc_addr(adc_addr), .dac_len(dac_len), .rdy(cnv_rdy), .din(bus_din),
    .busy(busy), .tmo_evt(tmo_evt), .sample(sample), .addr(bus_addr),
    .dout(bus_dout), .oe(bus_oe), .cs_n(cnv_cs_n), .rc_n(cnv_rc_n),
    .wr_n(dac_wr_n), .irq(irq)
  );
endmodule

// File: rtl/pconv_chk.sv
module pconv_chk #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_dout,
  input logic          bus_oe,
  input logic          cnv_cs_n,
  input logic          cnv_rc_n,
  input logic          dac_wr_n,
  input logic          irq
);
  a_r2_rc_inside_cs: assert property (@(posedge clk) disable iff (rst)
    !cnv_rc_n |-> !cnv_cs_n);

  a_r7_single_owner: assert property (@(posedge clk) disable iff (rst)
    !cnv_cs_n |-> !bus_oe);

  a_r8_strobe_stable: assert property (@(posedge clk) disable iff (rst)
    !dac_wr_n |-> (bus_oe && $stable(bus_addr) && $stable(bus_dout)));

  a_r8_hold_cycle: assert property (@(posedge clk) disable iff (rst)
    $rose(dac_wr_n) |-> bus_oe);

  a_r3_irq_one_cycle: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  a_r3_irq_at_release: assert property (@(posedge clk) disable iff (rst)
    irq |-> (cnv_cs_n && !$past(cnv_cs_n)));
endmodule

bind pconv_top pconv_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_dout(bus_dout),
  .bus_oe(bus_oe), .cnv_cs_n(cnv_cs_n), .cnv_rc_n(cnv_rc_n),
  .dac_wr_n(dac_wr_n), .irq(irq)
);

// File: tb/pconv_top_tb.sv
`timescale 1ns/1ps
module pconv_top_tb;
  logic        clk = 1'b0, rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0, reg_raddr = '0;
  logic [31:0] reg_wdata = '0;
  logic        int_trig = 1'b0, ext_trig = 1'b0, cnv_rdy = 1'b0;
  logic [15:0] bus_din = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  bus_addr;
  logic [15:0] bus_dout;
  logic        bus_oe, cnv_cs_n, cnv_rc_n, dac_wr_n, irq;

  pconv_top u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .int_trig(int_trig), .ext_trig(ext_trig), .cnv_rdy(cnv_rdy),
    .bus_din(bus_din), .bus_addr(bus_addr), .bus_dout(bus_dout),
    .bus_oe(bus_oe), .cnv_cs_n(cnv_cs_n), .cnv_rc_n(cnv_rc_n),
    .dac_wr_n(dac_wr_n), .irq(irq)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit fin = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model, advanced on every rising edge ----------------
  int          phase, left, waited;
  bit          m_cs, m_rc, m_wr, m_oe, m_irq, m_err;
  logic [7:0]  m_addr;
  logic [15:0] m_dout, m_sample;
  logic [31:0] m_rdata;
  bit          c_w16, c_ext, c_int;
  int          c_conv, c_dly, c_tmo, c_dlen;
  logic [7:0]  c_aadr, l_daddr;
  logic [15:0] l_ddata;
  bit          x1, x2, x3;

  always @(posedge clk) begin
    if (rst) begin
      phase = 0; left = 0; waited = 0;
      m_cs = 1; m_rc = 1; m_wr = 1; m_oe = 0; m_irq = 0; m_err = 0;
      m_addr = 0; m_dout = 0; m_sample = 0; m_rdata = 0;
      c_w16 = 0; c_ext = 0; c_int = 0; c_conv = 1; c_dly = 0; c_tmo = 16; c_dlen = 1;
      c_aadr = 0; l_daddr = 0; l_ddata = 0; x1 = 0; x2 = 0; x3 = 0;
    end else begin
      bit trg, dgo, eset;
      logic [31:0] nrd;
      trg  = (reg_we && reg_addr == 3'd5) || (c_int && int_trig) || (c_ext && x2 && !x3);
      dgo  = reg_we && reg_addr == 3'd4;
      eset = 0;
      case (reg_raddr)
        3'd0: nrd = {29'd0, c_int, c_ext, c_w16};
        3'd1: nrd = {c_tmo[15:0], c_dly[7:0], c_conv[7:0]};
        3'd2: nrd = {24'd0, c_aadr};
        3'd3: nrd = {24'd0, c_dlen[7:0]};
        3'd4: nrd = {8'd0, l_ddata, l_daddr};
        3'd6: nrd = {16'd0, m_sample};
        3'd7: nrd = {30'd0, phase != 0, m_err};
        default: nrd = 0;
      endcase
      m_irq = 0;
      case (phase)
        0: if (trg) begin phase = 1; m_cs = 0; m_addr = c_aadr; end
           else if (dgo) begin
             phase = 5; m_oe = 1; m_addr = reg_wdata[7:0];
             m_dout = c_w16 ? reg_wdata[23:8] : {8'd0, reg_wdata[15:8]};
           end
        1: begin phase = 2; m_rc = 0; left = (c_conv == 0) ? 1 : c_conv; end
        2: begin left--; if (left == 0) begin phase = 3; m_rc = 1; waited = 0; end end
        3: if (cnv_rdy) begin phase = 4; left = c_dly + 1; end
           else begin
             waited++;
             if (waited >= ((c_tmo == 0) ? 1 : c_tmo)) begin phase = 0; m_cs = 1; eset = 1; end
           end
        4: begin
             left--;
             if (left == 0) begin
               phase = 0; m_cs = 1; m_irq = 1;
               m_sample = c_w16 ? bus_din : {8'd0, bus_din[7:0]};
             end
           end
        5: begin phase = 6; m_wr = 0; left = (c_dlen == 0) ? 1 : c_dlen; end
        6: begin left--; if (left == 0) begin phase = 7; m_wr = 1; end end
        default: begin phase = 0; m_oe = 0; end
      endcase
      if (eset) m_err = 1;
      else if (reg_we && reg_addr == 3'd7 && reg_wdata[0]) m_err = 0;
      if (reg_we) begin
        case (reg_addr)
          3'd0: begin c_w16 = reg_wdata[0]; c_ext = reg_wdata[1]; c_int = reg_wdata[2]; end
          3'd1: begin c_conv = reg_wdata[7:0]; c_dly = reg_wdata[15:8]; c_tmo = reg_wdata[31:16]; end
          3'd2: c_aadr = reg_wdata[7:0];
          3'd3: c_dlen = reg_wdata[7:0];
          3'd4: begin l_daddr = reg_wdata[7:0]; l_ddata = reg_wdata[23:8]; end
          default: ;
        endcase
      end
      x3 = x2; x2 = x1; x1 = ext_trig;
      m_rdata = nrd;
    end
  end

  // every-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (!rst && !fin) begin
      chk(cnv_cs_n == m_cs, "R2 select", cnv_cs_n, m_cs);
      chk(cnv_rc_n == m_rc, "R2 read/convert", cnv_rc_n, m_rc);
      chk(irq == m_irq, "R3 interrupt", irq, m_irq);
      chk(dac_wr_n == m_wr, "R8 strobe", dac_wr_n, m_wr);
      chk(bus_oe == m_oe, "R8 data enable", bus_oe, m_oe);
      chk(bus_addr == m_addr, "R9 address", bus_addr, m_addr);
      chk(bus_dout == m_dout, "R4 output data", bus_dout, m_dout);
      chk(reg_rdata == m_rdata, "R10 read data", reg_rdata, m_rdata);
    end
  end

  // converter responder and edge counters
  int adc_lat = 3, rcnt = 0, cs_falls = 0, wr_falls = 0;
  bit seen = 0;
  logic prev_cs = 1'b1, prev_wr = 1'b1;
  always @(negedge clk) begin
    if (cnv_cs_n) begin cnv_rdy = 0; seen = 0; rcnt = 0; end
    else if (!cnv_rc_n) seen = 1;
    else if (seen) begin rcnt++; if (rcnt >= adc_lat) cnv_rdy = 1; end
    if (prev_cs && !cnv_cs_n) cs_falls++;
    if (prev_wr && !dac_wr_n) wr_falls++;
    prev_cs = cnv_cs_n;
    prev_wr = dac_wr_n;
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd_expect(input logic [2:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); reg_raddr = a;
    @(negedge clk); chk(reg_rdata == e, tag, reg_rdata, e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_int();
    @(negedge clk); int_trig = 1;
    @(negedge clk); int_trig = 0;
  endtask

  task automatic finish_run();
    fin = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL R10 watchdog act=%h exp=%h", 32'd0, 32'd1);
      finish_run();
    end
  end

  initial begin
    int f, g;
    idle(3); rst = 0; idle(1);
    // R1 reset state
    chk(cnv_cs_n && cnv_rc_n && dac_wr_n, "R1 strobes high", {cnv_cs_n, cnv_rc_n, dac_wr_n}, 3'b111);
    chk(!bus_oe && !irq && bus_addr == 0 && bus_dout == 0, "R1 outputs zero", {bus_oe, irq, bus_addr, bus_dout}, 0);
    rd_expect(3'd0, 32'h0, "R1 control reset");
    rd_expect(3'd1, 32'h0010_0001, "R1 timing reset");
    rd_expect(3'd3, 32'h1, "R1 strobe width reset");
    rd_expect(3'd7, 32'h0, "R1 status reset");

    // R2 R3 R9: 16-bit conversion by register start
    wr(3'd0, 32'h1); wr(3'd1, {16'd20, 8'd2, 8'd3}); wr(3'd2, 32'h5A);
    bus_din = 16'hBEEF; adc_lat = 4;
    wr(3'd5, 0); idle(40);
    rd_expect(3'd6, 32'hBEEF, "R4 16-bit sample");
    chk(bus_addr == 8'h5A, "R9 conversion address held", bus_addr, 8'h5A);

    // R6 internal trigger, 8-bit width
    wr(3'd0, 32'h4); bus_din = 16'h12C3;
    pulse_int(); idle(40);
    rd_expect(3'd6, 32'h00C3, "R4 8-bit sample by R6 internal trigger");

    // R6 disabled internal trigger
    wr(3'd0, 32'h0); f = cs_falls;
    pulse_int(); idle(12);
    chk(cs_falls == f, "R6 internal trigger disabled", cs_falls, f);

    // R6 external trigger, level held long
    wr(3'd0, 32'h3); bus_din = 16'h7788; f = cs_falls;
    @(negedge clk); ext_trig = 1; idle(50);
    @(negedge clk); ext_trig = 0; idle(6);
    chk(cs_falls == f + 1, "R6 one conversion per external edge", cs_falls, f + 1);
    rd_expect(3'd6, 32'h7788, "R6 external trigger sample");

    // R6 external disabled
    wr(3'd0, 32'h1); f = cs_falls;
    @(negedge clk); ext_trig = 1; idle(12);
    @(negedge clk); ext_trig = 0; idle(6);
    chk(cs_falls == f, "R6 external trigger disabled", cs_falls, f);

    // R7 requests while busy
    wr(3'd0, 32'h5); adc_lat = 8; bus_din = 16'h4444; f = cs_falls; g = wr_falls;
    wr(3'd5, 0); idle(1); wr(3'd5, 0);
    wr(3'd4, {8'd0, 16'hDEAD, 8'h11});
    pulse_int(); idle(40);
    chk(cs_falls == f + 1, "R7 start while busy ignored", cs_falls, f + 1);
    chk(wr_falls == g, "R7 output write while busy ignored", wr_falls, g);
    rd_expect(3'd6, 32'h4444, "R7 sample from accepted conversion");

    // R5 timeout and sticky error
    wr(3'd1, {16'd5, 8'd0, 8'd2}); adc_lat = 60; bus_din = 16'h9999;
    wr(3'd5, 0); idle(30);
    rd_expect(3'd7, 32'h1, "R5 error set on timeout");
    rd_expect(3'd6, 32'h4444, "R5 sample kept on timeout");
    wr(3'd7, 32'h0);
    rd_expect(3'd7, 32'h1, "R5 error sticky");
    wr(3'd7, 32'h1);
    rd_expect(3'd7, 32'h0, "R5 error cleared");

    // R2 zero counts treated as one, ready one cycle in
    wr(3'd1, 32'h0); adc_lat = 1; bus_din = 16'h0F0F;
    wr(3'd5, 0); idle(20);
    rd_expect(3'd6, 32'h0F0F, "R2 zero counts capture");
    adc_lat = 2;
    wr(3'd5, 0); idle(20);
    rd_expect(3'd7, 32'h1, "R5 timeout of one cycle");
    wr(3'd7, 32'h1);

    // R8 output write, 16-bit then 8-bit with zero width
    g = wr_falls;
    wr(3'd3, 32'h3); wr(3'd4, {8'd0, 16'hA55A, 8'h33}); idle(15);
    chk(wr_falls == g + 1, "R8 one strobe", wr_falls, g + 1);
    rd_expect(3'd4, {8'd0, 16'hA55A, 8'h33}, "R10 last output word");
    wr(3'd0, 32'h0); wr(3'd3, 32'h0); wr(3'd4, {8'd0, 16'h1234, 8'h77}); idle(10);
    chk(bus_dout == 16'h0034, "R4 8-bit output upper byte zero", bus_dout, 16'h0034);
    chk(bus_addr == 8'h77, "R9 output address held", bus_addr, 8'h77);
    chk(!bus_oe && dac_wr_n, "R8 enable released", {bus_oe, dac_wr_n}, 2'b01);

    finish_run();
  end
endmodule